// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block turns asynchronous external interrupt pins into clean, single-cycle interrupt request pulses. It serves seven ordinary pins and one shared pin. The shared pin is the non-maskable source and can also feed interrupt line 13. Each pin is first passed through a synchroniser. A history flop then compares the synchronised level with its value one cycle earlier. Each pin's own control register picks which transition counts: falling, rising or both. An enable bit in that register gates the resulting pulse.

A small register port sets up the pins. Each control register holds a two-bit polarity field and an enable bit. The shared pin's register also holds a routing bit that decides what drives line 13. With the bit clear, line 13 follows a timer interrupt input. With the bit set, line 13 carries the shared pin's pulse. Edges that occur while a pin is disabled are dropped, not stored. The history flop keeps tracking the pin while it is disabled, so turning the enable on never creates a pulse by itself.

Top module: `ext_irq_edge_unit`

## Requirements
- R1: After reset every control register reads 0, and `irq_pulse`, `nmi_req` and `line13_req` (with `timer_irq` low) are 0.
- R2: Addresses 0 to 6 select the control registers of pins 1 to 7, and address 7 selects the shared-pin register. Reads are combinational. Bits 3:2 hold the polarity, bit 0 the enable, and bit 1 the line-13 routing (shared register only). Every other bit, and bit 1 of an ordinary pin register, reads 0.
- R3: Polarity 2'b00 makes a high-to-low transition of the pin fire a pulse, and only that transition.
- R4: Polarity 2'b01 makes a low-to-high transition fire a pulse, and only that transition.
- R5: Polarity 2'b10 behaves exactly like 2'b00: falling transitions only.
- R6: Polarity 2'b11 fires a pulse on every transition, either direction.
- R7: A pin change applied before clock edge k shows as a pulse between edges k+2 and k+3. Each qualifying transition gives exactly one pulse one cycle wide, so transitions in consecutive cycles give pulses in consecutive cycles.
- R8: With the enable bit at 0, no pulse is produced and the transition is not remembered. Setting the enable later, with the pin already at its new level, produces no pulse.
- R9: The shared pin follows the same polarity and enable rules and drives `nmi_req` with the same latency.
- R10: With routing bit 1 at 0, `line13_req` equals `timer_irq` combinationally. With it at 1, `line13_req` equals `nmi_req` and `timer_irq` is ignored.
- R11: Pins are independent: simultaneous transitions on several pins each produce their own pulse according to their own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0-6 ordinary pins, 7 shared pin |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| ext_pin | input | 7 | Asynchronous ordinary interrupt pins 1 to 7 |
| shared_pin | input | 1 | Asynchronous shared non-maskable / line-13 pin |
| timer_irq | input | 1 | Timer interrupt request offered to line 13 |
| irq_pulse | output | 7 | One-cycle request pulses for pins 1 to 7 |
| nmi_req | output | 1 | One-cycle request pulse from the shared pin |
| line13_req | output | 1 | Interrupt line 13 request, routed per register bit 1 |

## Verification
A stale history flop shows up at the ports as a pulse that has no matching pin transition, or as a pulse one cycle early or late. Either shows within three clock edges of the stimulus. A wrong polarity decode or a leaked enable gives a pulse of the wrong direction, or one on a disabled pin, at exactly the cycle a correct design would have stayed quiet. A corrupted routing bit moves `line13_req` away from `timer_irq` in the same cycle, because that path is combinational. The scoreboard expects a result for a fixed cycle after every pin change and also flags any pulse it did not predict, so each of these faults is caught at its first occurrence.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Width of the meaningful part of a control register.
  localparam int CTRL_W = 4;

  // Polarity selector values; both fall codes share one meaning.
  typedef enum logic [1:0] {
    POL_FALL_A = 2'b00,
    POL_RISE   = 2'b01,
    POL_FALL_B = 2'b10,
    POL_BOTH   = 2'b11
  } pol_e;

  // Packed so that pol sits at bits 3:2, route at 1, en at 0.
  typedef struct packed {
    pol_e pol;
    logic route;
    logic en;
  } ctrl_t;

  // Decide whether a prev->cur transition qualifies under pol.
  function automatic logic edge_hit(pol_e pol, logic prev, logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (pol)
      POL_RISE: return rise;
      POL_BOTH: return rise | fall;
      default:  return fall;
    endcase
  endfunction

  // Convert raw register bits into a control word; routing kept only
  // where the register owns it.
  function automatic ctrl_t to_ctrl(logic [CTRL_W-1:0] raw, logic has_route);
    ctrl_t c;
    c.pol   = pol_e'(raw[3:2]);
    c.route = raw[1] & has_route;
    c.en    = raw[0];
    return c;
  endfunction

  // Line 13 source selection.
  function automatic logic pick_line13(logic route_pin, logic pin_pulse, logic timer);
    return route_pin ? pin_pulse : timer;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  if (STAGES > 1) begin : g_multi
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/irq_edge_cell.sv
module irq_edge_cell
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic en,
  input  pol_e pol,
  output logic level_o,
  output logic hist_o,
  output logic pulse_o
);

  logic hist_q;
  logic pulse_q;
  logic hit_w;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin),
    .q     (level_o)
  );

  // History follows the synchronised level regardless of enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= level_o;
  end

  assign hit_w = edge_hit(pol, hist_q, level_o);

  // A hit that arrives while disabled is dropped, not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= en & hit_w;
  end

  assign hist_o  = hist_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 7,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             pin_ctrl [NUM_PINS],
  output ctrl_t             shr_ctrl
);

  localparam logic [ADDR_W-1:0] SHR_ADDR = ADDR_W'(NUM_PINS);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pin_ctrl[i] <= '0;
      else if (we && addr == ADDR_W'(i))
        pin_ctrl[i] <= to_ctrl(wdata[CTRL_W-1:0], 1'b0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shr_ctrl <= '0;
    else if (we && addr == SHR_ADDR)
      shr_ctrl <= to_ctrl(wdata[CTRL_W-1:0], 1'b1);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr == ADDR_W'(i)) rdata[CTRL_W-1:0] = pin_ctrl[i];
    end
    if (addr == SHR_ADDR) rdata[CTRL_W-1:0] = shr_ctrl;
  end

endmodule

// File: rtl/ext_irq_edge_unit.sv
module ext_irq_edge_unit
  import ext_irq_pkg::*;
#(
  parameter  int NUM_PINS    = 7,
  parameter  int SYNC_STAGES = 2,
  parameter  int DATA_W      = 16,
  localparam int ADDR_W      = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic                shared_pin,
  input  logic                timer_irq,
  output logic [NUM_PINS-1:0] irq_pulse,
  output logic                nmi_req,
  output logic                line13_req
);

  ctrl_t pin_ctrl [NUM_PINS];
  ctrl_t shr_ctrl;

  // Named internal events, observed by the bound checker.
  logic [NUM_PINS-1:0]   pin_en_w;
  logic [2*NUM_PINS-1:0] pin_pol_w;
  logic [NUM_PINS-1:0]   pin_level_w;
  logic [NUM_PINS-1:0]   pin_hist_w;
  logic [NUM_PINS-1:0]   unused_route_w;
  logic                  shr_en_w;
  logic [1:0]            shr_pol_w;
  logic                  shr_route_w;
  logic                  shr_level_w;
  logic                  shr_hist_w;
  logic                  shr_pulse_w;
  logic                  unused_routes;

  irq_ctrl_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .pin_ctrl (pin_ctrl),
    .shr_ctrl (shr_ctrl)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    assign pin_en_w[i]           = pin_ctrl[i].en;
    assign pin_pol_w[2*i +: 2]   = pin_ctrl[i].pol;
    assign unused_route_w[i]     = pin_ctrl[i].route;

    irq_edge_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (ext_pin[i]),
      .en      (pin_ctrl[i].en),
      .pol     (pin_ctrl[i].pol),
      .level_o (pin_level_w[i]),
      .hist_o  (pin_hist_w[i]),
      .pulse_o (irq_pulse[i])
    );
  end

  assign unused_routes = ^unused_route_w;

  assign shr_en_w    = shr_ctrl.en;
  assign shr_pol_w   = shr_ctrl.pol;
  assign shr_route_w = shr_ctrl.route;

  irq_edge_cell #(.SYNC_STAGES(SYNC_STAGES)) u_shr_cell (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (shared_pin),
    .en      (shr_ctrl.en),
    .pol     (shr_ctrl.pol),
    .level_o (shr_level_w),
    .hist_o  (shr_hist_w),
    .pulse_o (shr_pulse_w)
  );

  assign nmi_req    = shr_pulse_w;
  assign line13_req = pick_line13(shr_route_w, shr_pulse_w, timer_irq);

endmodule

// File: rtl/irq_edge_chk.sv
module irq_edge_chk #(
  parameter int NUM_PINS = 7,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   en_v,
  input logic [2*NUM_PINS-1:0] pol_v,
  input logic [NUM_PINS-1:0]   level_v,
  input logic [NUM_PINS-1:0]   hist_v,
  input logic [NUM_PINS-1:0]   irq_pulse,
  input logic                  sh_en,
  input logic [1:0]            sh_pol,
  input logic                  sh_route,
  input logic                  sh_level,
  input logic                  sh_hist,
  input logic                  nmi_req,
  input logic                  timer_irq,
  input logic                  line13_req,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_rdata
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R8: a pulse needs the enable to have been set one cycle earlier
    a_r8_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |-> $past(en_v[i]));

    // R7: every pulse stems from a level change seen by the history flop
    a_r7_pulse_has_change: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[i] |-> ($past(level_v[i]) != $past(hist_v[i])));

    // R4: rising polarity only passes low-to-high
    a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse[i] && $past(pol_v[2*i +: 2]) == 2'b01)
        |-> ($past(level_v[i]) && !$past(hist_v[i])));

    // R3 and R5: both falling codes only pass high-to-low
    a_r5_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse[i] && !$past(pol_v[2*i]))
        |-> (!$past(level_v[i]) && $past(hist_v[i])));
  end

  // R9: shared pin obeys its own enable and change rule
  a_r9_nmi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> ($past(sh_en) && ($past(sh_level) != $past(sh_hist))));

  a_r9_nmi_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && $past(sh_pol) == 2'b01) |-> ($past(sh_level) && !$past(sh_hist)));

  // R10: line 13 source selection
  a_r10_timer_path: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_route |-> (line13_req == timer_irq));

  a_r10_pin_path: assert property (@(posedge clk) disable iff (!rst_n)
    sh_route |-> (line13_req == nmi_req));

  // R2: unused bits always read as zero; ordinary registers have no route bit
  a_r2_read_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(NUM_PINS)) |-> ((reg_rdata & ~DATA_W'(4'hD)) == '0));

  a_r2_shared_read_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(NUM_PINS)) |-> ((reg_rdata & ~DATA_W'(4'hF)) == '0));

endmodule

bind ext_irq_edge_unit irq_edge_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_v       (pin_en_w),
  .pol_v      (pin_pol_w),
  .level_v    (pin_level_w),
  .hist_v     (pin_hist_w),
  .irq_pulse  (irq_pulse),
  .sh_en      (shr_en_w),
  .sh_pol     (shr_pol_w),
  .sh_route   (shr_route_w),
  .sh_level   (shr_level_w),
  .sh_hist    (shr_hist_w),
  .nmi_req    (nmi_req),
  .timer_irq  (timer_irq),
  .line13_req (line13_req),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/tb_ext_irq_edge_unit.sv
module tb_ext_irq_edge_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pins = 8'hFF;       // bit 7 is the shared pin
  logic        timer_irq = 1'b0;
  logic [NP-1:0] irq_pulse;
  logic        nmi_req;
  logic        line13_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [3:0] cfg [8];               // bench shadow of the control bits

  typedef struct {
    int         due;
    logic [8:0] m;
    string      tag;
  } item_t;
  item_t sb [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_edge_unit dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ext_pin    (pins[6:0]),
    .shared_pin (pins[7]),
    .timer_irq  (timer_irq),
    .irq_pulse  (irq_pulse),
    .nmi_req    (nmi_req),
    .line13_req (line13_req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Which transitions each polarity code accepts, from the requirement text.
  function automatic logic fires(logic [1:0] pol, logic was, logic now);
    if (was == now)      return 1'b0;
    if (pol == 2'b11)    return 1'b1;
    if (pol == 2'b01)    return now;
    return was;
  endfunction

  // Monitor: pops due items, flags anything not predicted.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [8:0] obs;
      logic [8:0] exp;
      bit         have;
      string      tag;
      obs  = {line13_req, nmi_req, irq_pulse};
      exp  = '0;
      have = 0;
      tag  = "R7";
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it   = sb.pop_front();
        exp  = it.m;
        tag  = it.tag;
        have = 1;
      end
      exp[8] = exp[8] | (timer_irq & ~cfg[7][1]);
      if (have) checks++;
      if (obs !== exp) begin
        if (!have) checks++;
        errors++;
        $display("FAIL %s: cycle %0d got %0h expected %0h", tag, cyc, obs, exp);
      end
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk);
    #1;
    cfg[a] = (a < NP) ? (d[3:0] & 4'hD) : d[3:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    check(req, reg_rdata, exp);
  endtask

  // Driver: applies a pin vector and predicts the pulse three edges later.
  task automatic drive(input logic [7:0] nv, input string tag);
    logic [8:0] m;
    @(negedge clk);
    m = '0;
    for (int i = 0; i < 8; i++)
      m[i] = cfg[i][0] & fires(cfg[i][3:2], pins[i], nv[i]);
    m[8] = m[7] & cfg[7][1];
    sb.push_back('{cyc + 3, m, tag});
    pins = nv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_timer(input logic v, input logic exp13, input string req);
    @(posedge clk);
    #2;
    timer_irq = v;
    #1;
    check(req, {15'd0, line13_req}, {15'd0, exp13});
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R7: watchdog got timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) cfg[i] = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state of registers and outputs
    for (int a = 0; a < 8; a++) rd(a, 16'h0000, "R1");
    check("R1", {7'd0, line13_req, nmi_req, irq_pulse}, 16'h0000);

    // R2: field layout and zero bits
    wr(0, 16'hFFFF);
    rd(0, 16'h000D, "R2");
    wr(7, 16'hFFFF);
    rd(7, 16'h000F, "R2");
    wr(4, 16'h1236);
    rd(4, 16'h0004, "R2");
    wr(0, 16'h0000); wr(7, 16'h0000); wr(4, 16'h0000);
    rd(0, 16'h0000, "R2");

    // Configure: pin1 00, pin2 01, pin3 10, pin4 11, pins5-7 01, shared 11 routed
    wr(0, 16'h0001); wr(1, 16'h0005); wr(2, 16'h0009); wr(3, 16'h000D);
    wr(4, 16'h0005); wr(5, 16'h0005); wr(6, 16'h0005); wr(7, 16'h000F);
    idle(3);

    // R3 R5 R6 R9 R11: all pins fall together
    drive(8'h00, "R11 fall R3 R5 R6 R9");
    idle(5);
    // R4 R6 R9 R11: all pins rise together
    drive(8'hFF, "R11 rise R4 R6 R9");
    idle(5);

    // R7: single edge gives one pulse one cycle wide
    drive(8'hFE, "R7 R3 single");
    drive(8'hFE, "R7 width");
    drive(8'hFE, "R7 width");
    idle(4);
    drive(8'hFF, "R3 rise ignored");
    idle(4);

    // R7: back-to-back transitions on a both-edge pin
    drive(8'hF7, "R7 b2b");
    drive(8'hFF, "R7 b2b");
    drive(8'hF7, "R7 b2b");
    drive(8'hFF, "R7 b2b");
    idle(5);

    // R8: disabled pin drops edges; enabling later produces nothing
    wr(3, 16'h000C);
    drive(8'hF7, "R8 disabled fall");
    idle(5);
    wr(3, 16'h000D);
    for (int i = 0; i < 4; i++) drive(8'hF7, "R8 enable no pulse");
    idle(3);
    drive(8'hFF, "R8 after enable");
    idle(5);
    wr(1, 16'h0004);
    drive(8'hFD, "R8 disabled");
    idle(4);
    drive(8'hFF, "R8 disabled rise");
    idle(5);

    // R9: shared pin with rising polarity only
    wr(7, 16'h0007);
    drive(8'h7F, "R9 fall ignored");
    idle(4);
    drive(8'hFF, "R9 rise");
    idle(5);

    // R10: timer routing
    wr(7, 16'h000D);
    set_timer(1'b1, 1'b1, "R10 timer high");
    set_timer(1'b0, 1'b0, "R10 timer low");
    set_timer(1'b1, 1'b1, "R10 timer high again");
    drive(8'h7F, "R10 nmi not on line13");
    idle(5);
    set_timer(1'b0, 1'b0, "R10 timer low");
    wr(7, 16'h000F);
    set_timer(1'b1, 1'b0, "R10 timer ignored");
    drive(8'hFF, "R10 pin on line13");
    idle(5);
    set_timer(1'b0, 1'b0, "R10 idle");

    while (sb.size() > 0) @(negedge clk);
    idle(5);
    done = 1;
    summary();
    $finish;
  end

endmodule